// File: doc/BRIEF.md
# Small-Object Block Allocator Front End

This block serves small heap requests from block addresses cached on chip. A request carries a byte size. Sizes up to 128 bytes map onto one of eight size classes, each 16 bytes wide. Each class keeps a short ring of free block addresses. An allocate takes the block at the head of its class ring. A free gives a block back at the head, so the most recently freed block is handed out first. A prefetcher tops up each ring at the tail. A per-class low-watermark output tells it which classes need refilling.

When the hardware cannot complete an operation, the response carries a fallback flag and software takes over. This happens for an oversized request, an allocate from an empty class, or a free into a full class. A prefetch push that finds no room is dropped and reported back. A flush command, used at a context switch, streams every cached address out to the memory side in a fixed order. While a flush is running, core requests fall back and prefetches are dropped.

Top module: `slab_alloc`

## Requirements
- R1: The size class is (size-1)>>4 for sizes 1 to 128, and size 0 selects class 0. Sizes 113 to 128 therefore select class 7, and 33 to 48 select class 2.
- R2: A request with size above 128 gets a response with the fallback flag set on the next cycle. It changes no ring.
- R3: An allocate to a non-empty class responds on the next cycle with rsp_valid_o=1 and rsp_fallback_o=0. rsp_addr_o carries the head block, and that block is removed.
- R4: An allocate to an empty class responds on the next cycle with rsp_fallback_o=1.
- R5: A free to a class holding fewer than 32 entries succeeds with rsp_fallback_o=0. The freed block is placed at the head, so the next allocate of that class returns it.
- R6: A free to a class holding 32 entries responds with rsp_fallback_o=1 and leaves the ring unchanged.
- R7: A prefetch push (pf_valid_i, pf_class_i, pf_addr_i) appends at the tail. Prefetched blocks are handed out in push order, after any blocks at the head.
- R8: A prefetch push is dropped, with pf_drop_o=1 on the next cycle, in two cases: the class already holds 32 entries, or a free to the same class fills it in the same cycle.
- R9: low_wm_o[c] is 1 exactly while class c holds fewer than 8 entries.
- R10: flush_req_i starts a drain. The drain outputs every entry on drain_valid_o/drain_class_o/drain_addr_o, one per cycle. Classes go in ascending order, and each class goes from head to tail. A one-cycle flush_done_o pulse follows, and all rings are then empty.
- R11: While flush_busy_o=1, core requests get fallback responses and prefetch pushes are dropped.
- R12: After reset all rings are empty, every low_wm_o bit is 1, and all valid, flag and pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core request strobe |
| req_free_i | input | 1 | 1 = free, 0 = allocate |
| req_size_i | input | SIZE_W | Request size in bytes |
| req_addr_i | input | ADDR_W | Block address being freed |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_fallback_o | output | 1 | Software must handle the request |
| rsp_addr_o | output | ADDR_W | Allocated block address (0 otherwise) |
| pf_valid_i | input | 1 | Prefetch push strobe |
| pf_class_i | input | CLS_W | Class targeted by the prefetch |
| pf_addr_i | input | ADDR_W | Block address pushed at the tail |
| pf_drop_o | output | 1 | Previous prefetch push was dropped |
| low_wm_o | output | NUM_CLASSES | Per-class low-occupancy flag |
| flush_req_i | input | 1 | Start draining all rings |
| flush_busy_o | output | 1 | Drain in progress |
| drain_valid_o | output | 1 | Drained entry strobe |
| drain_class_o | output | CLS_W | Class of the drained entry |
| drain_addr_o | output | ADDR_W | Drained block address |
| flush_done_o | output | 1 | One-cycle pulse after the last drained entry |

## Verification
The first symptom of a head pointer that is off by one is a wrong rsp_addr_o on the very next allocate to that class. A stale tail pointer shows later, as prefetched blocks that come out in the wrong order or missing. An occupancy counter that drifts shows up at once on low_wm_o. At the boundaries it also shows as a wrong fallback or drop flag, in the cycle after an allocate to an empty class, a free into a full class or a prefetch into a full class. A fault in the drain walk appears only at a flush, as a wrong order, count or class tag on the drain port, or as a done pulse that comes too early.

// File: rtl/slab_pkg.sv
package slab_pkg;
  localparam int unsigned DEF_NUM_CLASSES = 8;
  localparam int unsigned DEF_DEPTH       = 32;
  localparam int unsigned DEF_CLASS_BYTES = 16;
  localparam int unsigned DEF_LOW_WM      = 8;

  typedef enum logic {
    FL_IDLE,
    FL_DRAIN
  } flush_state_e;
endpackage

// File: rtl/slab_class_map.sv
module slab_class_map #(
  parameter int unsigned SIZE_W      = 16,
  parameter int unsigned MAX_SIZE    = 128,
  parameter int unsigned CLASS_BYTES = 16,
  parameter int unsigned CLS_W       = 3
) (
  input  logic [SIZE_W-1:0] size_i,
  output logic [CLS_W-1:0]  cls_o,
  output logic              oversize_o
);
  localparam int unsigned SHIFT = $clog2(CLASS_BYTES);

  logic [SIZE_W-1:0] size_m1;
  logic [SIZE_W-1:0] shifted;

  always_comb begin
    size_m1    = (size_i == '0) ? '0 : size_i - SIZE_W'(1);
    shifted    = size_m1 >> SHIFT;
    cls_o      = shifted[CLS_W-1:0];
    oversize_o = size_i > SIZE_W'(MAX_SIZE);
  end
endmodule

// File: rtl/slab_list.sv
// Ring of free block addresses; core side at head, prefetch side at tail.
// DEPTH must be a power of two. Caller guarantees no pop when empty and
// no push when full, and never pops and pushes at the head together.
module slab_list #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = PW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic              push_head_i,
  input  logic [ADDR_W-1:0] head_addr_i,
  input  logic              push_tail_i,
  input  logic [ADDR_W-1:0] tail_addr_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [CW-1:0]     count_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     head_q, tail_q, head_dec;
  logic [CW-1:0]     count_q;

  assign head_dec    = head_q - PW'(1);
  assign head_addr_o = mem_q[head_q];
  assign count_o     = count_q;
  assign empty_o     = (count_q == '0);
  assign full_o      = (count_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop_i)            head_q <= head_q + PW'(1);
      else if (push_head_i) head_q <= head_dec;
      if (push_tail_i)      tail_q <= tail_q + PW'(1);
      count_q <= count_q + CW'(push_head_i) + CW'(push_tail_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_head_i) mem_q[head_dec] <= head_addr_i;
    if (push_tail_i) mem_q[tail_q]   <= tail_addr_i;
  end
endmodule

// File: rtl/slab_flush_ctrl.sv
// Walks classes in ascending order, popping one entry per cycle until empty.
module slab_flush_ctrl
  import slab_pkg::*;
#(
  parameter int unsigned NUM_CLASSES = 8,
  localparam int unsigned CLS_W      = $clog2(NUM_CLASSES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   flush_req_i,
  input  logic [NUM_CLASSES-1:0] empty_i,
  output logic                   busy_o,
  output logic [NUM_CLASSES-1:0] pop_o,
  output logic [CLS_W-1:0]       cls_o,
  output logic                   done_o
);
  localparam logic [CLS_W-1:0] LAST = CLS_W'(NUM_CLASSES - 1);

  flush_state_e     state_q;
  logic [CLS_W-1:0] cls_q;
  logic             done_q;

  assign busy_o = (state_q == FL_DRAIN);
  assign cls_o  = cls_q;
  assign done_o = done_q;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_pop
    assign pop_o[c] = busy_o && (cls_q == CLS_W'(c)) && !empty_i[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FL_IDLE;
      cls_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        FL_IDLE: if (flush_req_i) begin
          state_q <= FL_DRAIN;
          cls_q   <= '0;
        end
        FL_DRAIN: if (empty_i[cls_q]) begin
          if (cls_q == LAST) begin
            state_q <= FL_IDLE;
            done_q  <= 1'b1;
          end else begin
            cls_q <= cls_q + CLS_W'(1);
          end
        end
        default: state_q <= FL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slab_alloc.sv
module slab_alloc
  import slab_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SIZE_W      = 16,
  parameter int unsigned NUM_CLASSES = DEF_NUM_CLASSES,
  parameter int unsigned DEPTH       = DEF_DEPTH,
  parameter int unsigned CLASS_BYTES = DEF_CLASS_BYTES,
  parameter int unsigned LOW_WM      = DEF_LOW_WM,
  localparam int unsigned CLS_W      = $clog2(NUM_CLASSES),
  localparam int unsigned MAX_SIZE   = NUM_CLASSES * CLASS_BYTES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_free_i,
  input  logic [SIZE_W-1:0]      req_size_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_fallback_o,
  output logic [ADDR_W-1:0]      rsp_addr_o,
  input  logic                   pf_valid_i,
  input  logic [CLS_W-1:0]       pf_class_i,
  input  logic [ADDR_W-1:0]      pf_addr_i,
  output logic                   pf_drop_o,
  output logic [NUM_CLASSES-1:0] low_wm_o,
  input  logic                   flush_req_i,
  output logic                   flush_busy_o,
  output logic                   drain_valid_o,
  output logic [CLS_W-1:0]       drain_class_o,
  output logic [ADDR_W-1:0]      drain_addr_o,
  output logic                   flush_done_o
);
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic [CLS_W-1:0]       req_cls;
  logic                   oversize;
  logic [ADDR_W-1:0]      head_addr [NUM_CLASSES];
  logic [CW-1:0]          count [NUM_CLASSES];
  logic [NUM_CLASSES-1:0] empty, full, pop, push_head, push_tail, drain_pop;
  logic [CLS_W-1:0]       flush_cls;
  logic                   busy, alloc_hit, free_hit, pf_same, pf_room, pf_ok;

  slab_class_map #(
    .SIZE_W(SIZE_W), .MAX_SIZE(MAX_SIZE), .CLASS_BYTES(CLASS_BYTES), .CLS_W(CLS_W)
  ) u_map (
    .size_i(req_size_i), .cls_o(req_cls), .oversize_o(oversize)
  );

  slab_flush_ctrl #(.NUM_CLASSES(NUM_CLASSES)) u_flush (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_req_i(flush_req_i),
    .empty_i(empty), .busy_o(busy), .pop_o(drain_pop),
    .cls_o(flush_cls), .done_o(flush_done_o)
  );

  assign flush_busy_o = busy;

  always_comb begin
    alloc_hit = req_valid_i && !req_free_i && !oversize && !busy && !empty[req_cls];
    free_hit  = req_valid_i &&  req_free_i && !oversize && !busy && !full[req_cls];
    // Admission counts a same-cycle core free into the same class.
    pf_same   = free_hit && (req_cls == pf_class_i);
    pf_room   = ({1'b0, count[pf_class_i]} + (CW+1)'(pf_same)) < (CW+1)'(DEPTH);
    pf_ok     = pf_valid_i && !busy && pf_room;
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    assign pop[c]       = (alloc_hit && req_cls == CLS_W'(c)) || drain_pop[c];
    assign push_head[c] = free_hit && req_cls == CLS_W'(c);
    assign push_tail[c] = pf_ok && pf_class_i == CLS_W'(c);
    assign low_wm_o[c]  = count[c] < CW'(LOW_WM);

    slab_list #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_list (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .pop_i(pop[c]),
      .push_head_i(push_head[c]), .head_addr_i(req_addr_i),
      .push_tail_i(push_tail[c]), .tail_addr_i(pf_addr_i),
      .head_addr_o(head_addr[c]), .count_o(count[c]),
      .empty_o(empty[c]), .full_o(full[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o    <= 1'b0;
      rsp_fallback_o <= 1'b0;
      rsp_addr_o     <= '0;
      pf_drop_o      <= 1'b0;
      drain_valid_o  <= 1'b0;
      drain_class_o  <= '0;
      drain_addr_o   <= '0;
    end else begin
      rsp_valid_o    <= req_valid_i;
      rsp_fallback_o <= req_valid_i && !(alloc_hit || free_hit);
      rsp_addr_o     <= alloc_hit ? head_addr[req_cls] : '0;
      pf_drop_o      <= pf_valid_i && !pf_ok;
      drain_valid_o  <= |drain_pop;
      drain_class_o  <= flush_cls;
      drain_addr_o   <= head_addr[flush_cls];
    end
  end
endmodule

// File: rtl/slab_alloc_checker.sv
module slab_alloc_checker #(
  parameter int unsigned SIZE_W   = 16,
  parameter int unsigned MAX_SIZE = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [SIZE_W-1:0] req_size_i,
  input logic              rsp_valid_o,
  input logic              rsp_fallback_o,
  input logic              pf_valid_i,
  input logic              pf_drop_o,
  input logic              flush_busy_o,
  input logic              flush_done_o,
  input logic              drain_valid_o
);
  assert_rsp_follows_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_oversize_fallback_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i > SIZE_W'(MAX_SIZE)) |=> rsp_fallback_o);

  assert_fallback_in_rsp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fallback_o |-> rsp_valid_o);

  assert_drop_has_push_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_drop_o |-> $past(pf_valid_i));

  assert_busy_core_fallback_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_busy_o && req_valid_i) |=> rsp_fallback_o);

  assert_busy_pf_drop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_busy_o && pf_valid_i) |=> pf_drop_o);

  assert_drain_in_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_valid_o |-> $past(flush_busy_o));

  assert_done_after_drain_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> (!flush_busy_o && !drain_valid_o));
endmodule

bind slab_alloc slab_alloc_checker #(.SIZE_W(SIZE_W), .MAX_SIZE(MAX_SIZE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_size_i(req_size_i),
  .rsp_valid_o(rsp_valid_o), .rsp_fallback_o(rsp_fallback_o),
  .pf_valid_i(pf_valid_i), .pf_drop_o(pf_drop_o), .flush_busy_o(flush_busy_o),
  .flush_done_o(flush_done_o), .drain_valid_o(drain_valid_o)
);

// File: tb/slab_alloc_tb_top.sv
`timescale 1ns/1ps
module slab_alloc_tb_top;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int NC = 8;
  localparam int CL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_free = 1'b0;
  logic [SW-1:0] req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid, rsp_fallback;
  logic [AW-1:0] rsp_addr;
  logic          pf_valid = 1'b0;
  logic [CL-1:0] pf_class = '0;
  logic [AW-1:0] pf_addr = '0;
  logic          pf_drop;
  logic [NC-1:0] low_wm;
  logic          flush_req = 1'b0, flush_busy, drain_valid, flush_done;
  logic [CL-1:0] drain_class;
  logic [AW-1:0] drain_addr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  slab_alloc dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_free_i(req_free), .req_size_i(req_size), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_fallback_o(rsp_fallback), .rsp_addr_o(rsp_addr),
    .pf_valid_i(pf_valid), .pf_class_i(pf_class), .pf_addr_i(pf_addr), .pf_drop_o(pf_drop),
    .low_wm_o(low_wm), .flush_req_i(flush_req), .flush_busy_o(flush_busy),
    .drain_valid_o(drain_valid), .drain_class_o(drain_class), .drain_addr_o(drain_addr),
    .flush_done_o(flush_done)
  );

  function automatic logic [AW-1:0] a_blk(int i); return 32'h0000_2000 + i * 32'h40;  endfunction
  function automatic logic [AW-1:0] b_blk(int i); return 32'h0005_0000 + i * 32'h100; endfunction

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Core request; outputs sampled one negedge later (one register stage).
  task automatic core(input bit fr, input int sz, input logic [AW-1:0] ad,
                      output bit v, output bit fb, output logic [AW-1:0] ra);
    @(negedge clk);
    req_valid = 1'b1; req_free = fr; req_size = SW'(sz); req_addr = ad;
    @(negedge clk);
    v = rsp_valid; fb = rsp_fallback; ra = rsp_addr;
    req_valid = 1'b0;
  endtask

  task automatic pf(input int c, input logic [AW-1:0] ad, output bit drop);
    @(negedge clk);
    pf_valid = 1'b1; pf_class = CL'(c); pf_addr = ad;
    @(negedge clk);
    drop = pf_drop;
    pf_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!rsp_valid && !rsp_fallback, "R12 rsp idle", AW'(rsp_valid), 0);
    check(low_wm == 8'hFF, "R12 low_wm all set", AW'(low_wm), 32'hFF);
    check(!pf_drop && !flush_busy && !drain_valid && !flush_done, "R12 flags idle",
          AW'({pf_drop, flush_busy, drain_valid, flush_done}), 0);
  endtask

  task automatic t_prefetch_fill();
    bit d;
    for (int i = 0; i < 10; i++) begin
      pf(2, a_blk(i), d);
      check(!d, "R7 pf accepted", AW'(d), 0);
      if (i == 6) check(low_wm[2], "R9 7 entries low", AW'(low_wm[2]), 1);
      if (i == 7) check(!low_wm[2], "R9 8 entries not low", AW'(low_wm[2]), 0);
    end
  endtask

  task automatic t_alloc_map();
    bit v, fb; logic [AW-1:0] ra, d;
    core(0, 33, 0, v, fb, ra);
    check(v && !fb && ra == a_blk(0), "R1 R3 size 33 class 2", ra, a_blk(0));
    core(0, 48, 0, v, fb, ra);
    check(v && !fb && ra == a_blk(1), "R1 R7 size 48 class 2 in order", ra, a_blk(1));
    core(0, 32, 0, v, fb, ra);
    check(v && fb, "R1 R4 size 32 class 1 empty", AW'(fb), 1);
    core(0, 0, 0, v, fb, ra);
    check(v && fb, "R1 R4 size 0 class 0 empty", AW'(fb), 1);
    pf(7, 32'h0007_7000, d[0]);
    core(0, 113, 0, v, fb, ra);
    check(!fb && ra == 32'h0007_7000, "R1 size 113 class 7", ra, 32'h0007_7000);
    core(0, 128, 0, v, fb, ra);
    check(v && fb, "R1 R4 size 128 class 7 now empty", AW'(fb), 1);
  endtask

  task automatic t_free_lifo();
    bit v, fb; logic [AW-1:0] ra;
    core(1, 40, 32'hDEAD_0040, v, fb, ra);
    check(v && !fb, "R5 free accepted", AW'(fb), 0);
    core(0, 40, 0, v, fb, ra);
    check(!fb && ra == 32'hDEAD_0040, "R5 freed block reused first", ra, 32'hDEAD_0040);
    core(0, 40, 0, v, fb, ra);
    check(!fb && ra == a_blk(2), "R7 tail entry after head", ra, a_blk(2));
  endtask

  task automatic t_oversize();
    bit v, fb; logic [AW-1:0] ra;
    core(0, 129, 0, v, fb, ra);
    check(v && fb, "R2 alloc 129 falls back", AW'(fb), 1);
    core(1, 200, 32'hBAD0_0000, v, fb, ra);
    check(v && fb, "R2 free 200 falls back", AW'(fb), 1);
    core(0, 40, 0, v, fb, ra);
    check(!fb && ra == a_blk(3), "R2 ring untouched", ra, a_blk(3));
  endtask

  task automatic t_full();
    bit v, fb, d; logic [AW-1:0] ra;
    int drops = 0;
    for (int i = 0; i < 32; i++) begin
      pf(5, b_blk(i), d);
      if (d) drops++;
    end
    check(drops == 0, "R7 32 pushes accepted", AW'(drops), 0);
    check(!low_wm[5], "R9 full class not low", AW'(low_wm[5]), 0);
    pf(5, 32'hFFFF_0000, d);
    check(d, "R8 pf into full dropped", AW'(d), 1);
    core(1, 90, 32'hCAFE_0500, v, fb, ra);
    check(v && fb, "R6 free into full falls back", AW'(fb), 1);
    core(0, 96, 0, v, fb, ra);
    check(!fb && ra == b_blk(0), "R6 head unchanged", ra, b_blk(0));
    // Same-cycle free fills the class: prefetch must be dropped.
    @(negedge clk);
    req_valid = 1'b1; req_free = 1'b1; req_size = SW'(90); req_addr = 32'hCAFE_0600;
    pf_valid = 1'b1; pf_class = CL'(5); pf_addr = 32'hFFFF_1000;
    @(negedge clk);
    check(!rsp_fallback && pf_drop, "R8 pf dropped behind same-cycle free",
          AW'({rsp_fallback, pf_drop}), 1);
    req_valid = 1'b0; pf_valid = 1'b0;
    core(0, 96, 0, v, fb, ra);
    check(!fb && ra == 32'hCAFE_0600, "R5 same-cycle free at head", ra, 32'hCAFE_0600);
  endtask

  task automatic t_flush();
    logic [AW-1:0] got_a[$];
    logic [CL-1:0] got_c[$];
    logic [AW-1:0] exp_a[$];
    logic [CL-1:0] exp_c[$];
    bit done = 0;
    bit v, fb; logic [AW-1:0] ra;
    for (int i = 4; i < 10; i++) begin exp_a.push_back(a_blk(i)); exp_c.push_back(3'd2); end
    for (int i = 1; i < 32; i++) begin exp_a.push_back(b_blk(i)); exp_c.push_back(3'd5); end
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    check(flush_busy, "R10 busy after request", AW'(flush_busy), 1);
    for (int n = 0; n < 200 && !done; n++) begin
      if (drain_valid) begin got_a.push_back(drain_addr); got_c.push_back(drain_class); end
      if (flush_done) done = 1;
      if (n == 2) begin
        req_valid = 1'b1; req_free = 1'b0; req_size = SW'(40);
        pf_valid = 1'b1; pf_class = CL'(3); pf_addr = 32'h0003_0000;
      end
      if (n == 3) begin
        check(rsp_valid && rsp_fallback, "R11 core falls back in flush", AW'(rsp_fallback), 1);
        check(pf_drop, "R11 pf dropped in flush", AW'(pf_drop), 1);
        req_valid = 1'b0; pf_valid = 1'b0;
      end
      @(negedge clk);
    end
    check(done, "R10 done pulse seen", AW'(done), 1);
    check(got_a.size() == exp_a.size(), "R10 drained count", AW'(got_a.size()), AW'(exp_a.size()));
    if (got_a.size() == exp_a.size())
      for (int i = 0; i < exp_a.size(); i++)
        check(got_a[i] == exp_a[i] && got_c[i] == exp_c[i], "R10 drain order", got_a[i], exp_a[i]);
    check(!flush_busy && low_wm == 8'hFF, "R10 rings empty after flush", AW'(low_wm), 32'hFF);
    core(0, 40, 0, v, fb, ra);
    check(fb, "R10 class 2 empty after flush", AW'(fb), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prefetch_fill();
    t_alloc_map();
    t_free_lifo();
    t_oversize();
    t_full();
    t_flush();
    finish_run();
  end
endmodule